// File: doc/BRIEF.md
# Translation Strobe Timing Controller

This block decides when the physical-side bus control outputs of an address translation unit are raised. They are the physical address strobe, bus error, halt and a request to give up the logical bus. It runs from a clock at twice the bus clock rate. An internal phase bit therefore knows whether each edge stands for a rising or a falling bus-clock edge, and every timing choice has half-clock resolution. A bus cycle is launched on a rising-phase edge. With no added delay, the strobes come up one half-clock later, on the falling edge.

Two settings are captured from configuration inputs while reset is held. The first is an added decision delay of whole half-clocks, which gives the translation cache compare time to settle before any strobe commits. The second is a mode bit that decides what table-search cycles do. They either keep the fixed falling-edge timing, or follow the same shifted edge as translation cycles. The cache compare itself lies outside the block and arrives as hit and fault inputs. These inputs are sampled on the edge where the strobes are raised.

When translation is switched off, the upper logical address goes straight to the physical bus. Protection faults and misses are then ignored, and the strobe is still raised for every cycle outside CPU space.

Top module: `xlat_strobe_timer`

## Requirements
- R1: While reset is high, all four strobes are low. The delay code and search mode captured on the last reset edge stay in force until the next reset.
- R2: A translation cycle raises its strobe 1+D half-clocks after the launch edge, where D equals the 2-bit delay code, except that code 3 gives D = 0. Odd counts land on a falling-phase edge and even counts on a rising-phase edge.
- R3: With search mode 1, a table-search cycle raises the address strobe exactly one half-clock after launch, whatever the delay code is.
- R4: With search mode 0, a table-search cycle raises the address strobe after the same 1+D half-clocks as a translation cycle.
- R5: With translation on, the outcome of a cycle outside CPU space is taken from the compare inputs on the strobe edge, not on the launch edge. A hit without a fault raises the address strobe. A hit with a fault raises bus error. A miss raises halt and relinquish together. Table-search cycles always raise only the address strobe. At most one of address strobe, bus error and relinquish is high.
- R6: With translation off, physical address bits 31..8 equal the logical ones. A cycle outside CPU space raises the address strobe whatever the hit and fault inputs say.
- R7: With translation on, physical address bits 31..8 equal the frame input. Bits 7..0 always equal the logical address.
- R8: A translation cycle flagged as CPU space raises no strobe, and the block is idle again on the edge where the strobe would have risen.
- R9: Raised strobes hold until cycle-end is sampled high, and they all drop on that same edge.
- R10: A launch request is ignored while a cycle is waiting or holding strobes, and also on a falling-phase edge.
- R11: Changes on the configuration inputs after reset has been released have no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock rate |
| rst | input | 1 | Synchronous reset, active high; configuration is captured while high |
| cfg_dly | input | DLY_W | Added decision delay code, captured in reset |
| cfg_search_fast | input | 1 | Table-search timing mode, captured in reset |
| cyc_start | input | 1 | Launch request for a bus cycle |
| cyc_search | input | 1 | Cycle is a table search (1) or a translation (0) |
| cyc_cpu | input | 1 | Cycle is in CPU space |
| xlat_on | input | 1 | Translation enabled |
| cmp_hit | input | 1 | Cache compare result: hit |
| cmp_fault | input | 1 | Cache compare result: access right violation |
| cyc_end | input | 1 | Cycle termination; strobes drop |
| la | input | ADDR_W | Logical address |
| frame | input | ADDR_W-PAGE_LSB | Translated upper address bits |
| pa | output | ADDR_W | Physical address |
| pas | output | 1 | Physical address strobe |
| berr | output | 1 | Bus error |
| halt | output | 1 | Halt |
| lbr | output | 1 | Logical bus relinquish request |

## Verification
The hardest situation to reach is a compare result that changes between the launch edge and the strobe edge, combined with delays that put the strobe on a rising-phase edge. Stimulus launches every cycle with inverted hit and fault values and writes the true values one half-clock later, so a design that samples too early gives the wrong outcome. The whole scenario set is repeated after a reset for each of the four delay codes under both search modes. Inside each pass, further launch requests are placed on falling-phase edges and during the wait and hold states, and the configuration inputs are moved after reset.

// File: rtl/xst_pkg.sv
package xst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } xst_state_t;

   typedef struct packed {
      logic pas;
      logic berr;
      logic halt;
      logic lbr;
   } xst_strobes_t;

   // Added half-clocks for a delay code; the all-ones code means none.
   function automatic int added_half(input int code, input int code_max);
      return (code == code_max) ? 0 : code;
   endfunction

endpackage

// File: rtl/xst_cfg_latch.sv
module xst_cfg_latch #(
   parameter int DLY_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DLY_W-1:0] cfg_dly,
   input  logic             cfg_search_fast,
   output logic [DLY_W-1:0] dly_q,
   output logic             fast_q
);

   // Sampled on every reset edge; the last one before release persists.
   always_ff @(posedge clk) begin
      if (rst) begin
         dly_q  <= cfg_dly;
         fast_q <= cfg_search_fast;
      end
   end

endmodule

// File: rtl/xst_edge_timer.sv
module xst_edge_timer #(
   parameter int DLY_W = 2,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             launch,
   input  logic             fast_path,
   input  logic [DLY_W-1:0] dly_q,
   output logic             rise_edge,
   output logic             due
);

   localparam int CODE_MAX = (1 << DLY_W) - 1;

   logic             ph;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] tgt;

   always_comb begin
      if (fast_path)
         tgt = CNT_W'(1);
      else
         tgt = CNT_W'(1 + xst_pkg::added_half(int'(dly_q), CODE_MAX));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph  <= 1'b0;
         cnt <= '0;
      end else begin
         ph <= ~ph;
         if (launch)
            cnt <= tgt;
         else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
      end
   end

   assign rise_edge = ~ph;
   assign due       = (cnt == CNT_W'(1));

endmodule

// File: rtl/xst_decide.sv
module xst_decide (
   input  logic                  search,
   input  logic                  cpu,
   input  logic                  xlat_on,
   input  logic                  hit,
   input  logic                  fault,
   output xst_pkg::xst_strobes_t nxt
);

   always_comb begin
      nxt = '0;
      if (search) begin
         nxt.pas = 1'b1;
      end else if (!cpu) begin
         if (!xlat_on || (hit && !fault)) begin
            nxt.pas = 1'b1;
         end else if (hit) begin
            nxt.berr = 1'b1;
         end else begin
            nxt.halt = 1'b1;
            nxt.lbr  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/xst_addr_mux.sv
module xst_addr_mux #(
   parameter int ADDR_W   = 32,
   parameter int PAGE_LSB = 8
) (
   input  logic                       xlat_on,
   input  logic [ADDR_W-1:0]          la,
   input  logic [ADDR_W-PAGE_LSB-1:0] frame,
   output logic [ADDR_W-1:0]          pa
);

   generate
      if (PAGE_LSB > 0) begin : g_split
         assign pa[PAGE_LSB-1:0] = la[PAGE_LSB-1:0];
         assign pa[ADDR_W-1:PAGE_LSB] = xlat_on ? frame : la[ADDR_W-1:PAGE_LSB];
      end else begin : g_whole
         assign pa = xlat_on ? frame : la;
      end
   endgenerate

endmodule

// File: rtl/xlat_strobe_timer.sv
module xlat_strobe_timer #(
   parameter int ADDR_W   = 32,
   parameter int PAGE_LSB = 8,
   parameter int DLY_W    = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [DLY_W-1:0]           cfg_dly,
   input  logic                       cfg_search_fast,
   input  logic                       cyc_start,
   input  logic                       cyc_search,
   input  logic                       cyc_cpu,
   input  logic                       xlat_on,
   input  logic                       cmp_hit,
   input  logic                       cmp_fault,
   input  logic                       cyc_end,
   input  logic [ADDR_W-1:0]          la,
   input  logic [ADDR_W-PAGE_LSB-1:0] frame,
   output logic [ADDR_W-1:0]          pa,
   output logic                       pas,
   output logic                       berr,
   output logic                       halt,
   output logic                       lbr
);

   import xst_pkg::*;

   localparam int CNT_W = $clog2((1 << DLY_W) + 1);

   generate
      if (DLY_W < 1 || DLY_W > 3) begin : g_bad_dly
         $error("DLY_W must lie in 1..3");
      end
      if (PAGE_LSB < 0 || PAGE_LSB >= ADDR_W) begin : g_bad_page
         $error("PAGE_LSB must lie below ADDR_W");
      end
   endgenerate

   logic [DLY_W-1:0] dly_q;
   logic             fast_q;
   logic             rise_edge;
   logic             due;
   logic             launch;
   logic             search_q;
   logic             cpu_q;
   xst_state_t       st;
   xst_strobes_t     nxt;
   xst_strobes_t     outs;

   xst_cfg_latch #(.DLY_W(DLY_W)) u_cfg (
      .clk             (clk),
      .rst             (rst),
      .cfg_dly         (cfg_dly),
      .cfg_search_fast (cfg_search_fast),
      .dly_q           (dly_q),
      .fast_q          (fast_q)
   );

   assign launch = cyc_start && (st == ST_IDLE) && rise_edge;

   xst_edge_timer #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .launch    (launch),
      .fast_path (cyc_search && fast_q),
      .dly_q     (dly_q),
      .rise_edge (rise_edge),
      .due       (due)
   );

   xst_decide u_decide (
      .search  (search_q),
      .cpu     (cpu_q),
      .xlat_on (xlat_on),
      .hit     (cmp_hit),
      .fault   (cmp_fault),
      .nxt     (nxt)
   );

   xst_addr_mux #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_addr (
      .xlat_on (xlat_on),
      .la      (la),
      .frame   (frame),
      .pa      (pa)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         outs     <= '0;
         search_q <= 1'b0;
         cpu_q    <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (launch) begin
                  st       <= ST_WAIT;
                  search_q <= cyc_search;
                  cpu_q    <= cyc_cpu;
               end
            end
            ST_WAIT: begin
               if (due) begin
                  outs <= nxt;
                  st   <= (nxt.pas || nxt.berr || nxt.lbr) ? ST_HOLD : ST_IDLE;
               end
            end
            ST_HOLD: begin
               if (cyc_end) begin
                  outs <= '0;
                  st   <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign pas  = outs.pas;
   assign berr = outs.berr;
   assign halt = outs.halt;
   assign lbr  = outs.lbr;

endmodule

// File: rtl/xst_checker.sv
module xst_checker #(
   parameter int DLY_W = 2,
   parameter int HI_W  = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             launch,
   input logic             cyc_search,
   input logic             cyc_cpu,
   input logic             cyc_end,
   input logic             xlat_on,
   input logic [DLY_W-1:0] dly_q,
   input logic             fast_q,
   input logic             pas,
   input logic             berr,
   input logic             halt,
   input logic             lbr,
   input logic [HI_W-1:0]  la_hi,
   input logic [HI_W-1:0]  pa_hi
);

   localparam int CODE_MAX = (1 << DLY_W) - 1;

   logic       ck_search;
   logic       ck_cpu;
   logic [3:0] ck_cnt;
   logic       any;
   logic [3:0] slow_exp;

   assign any      = pas || berr || lbr;
   assign slow_exp = 4'(2 + xst_pkg::added_half(int'(dly_q), CODE_MAX));

   always_ff @(posedge clk) begin
      if (rst) begin
         ck_search <= 1'b0;
         ck_cpu    <= 1'b0;
         ck_cnt    <= 4'd0;
      end else if (launch) begin
         ck_search <= cyc_search;
         ck_cpu    <= cyc_cpu;
         ck_cnt    <= 4'd1;
      end else if (ck_cnt != 4'd0 && ck_cnt != 4'd15) begin
         ck_cnt <= ck_cnt + 4'd1;
      end
   end

   assert_xlat_edge_R2: assert property (@(posedge clk) disable iff (rst)
      ($rose(any) && !ck_search) |-> (ck_cnt == slow_exp));

   assert_search_fast_edge_R3: assert property (@(posedge clk) disable iff (rst)
      ($rose(any) && ck_search && fast_q) |-> (ck_cnt == 4'd2));

   assert_search_slow_edge_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(any) && ck_search && !fast_q) |-> (ck_cnt == slow_exp));

   assert_single_outcome_R5: assert property (@(posedge clk) disable iff (rst)
      $countones({pas, berr, lbr}) <= 1);

   assert_berr_no_halt_R5: assert property (@(posedge clk) disable iff (rst)
      berr |-> !halt);

   assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
      !xlat_on |-> (pa_hi == la_hi));

   assert_cpu_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (ck_cpu && !ck_search) |-> !any);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (any && !cyc_end) |=> $stable({pas, berr, halt, lbr}));

   assert_release_R9: assert property (@(posedge clk) disable iff (rst)
      (any && cyc_end) |=> !(pas || berr || halt || lbr));

endmodule

bind xlat_strobe_timer xst_checker #(.DLY_W(DLY_W), .HI_W(ADDR_W - PAGE_LSB)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .launch     (launch),
   .cyc_search (cyc_search),
   .cyc_cpu    (cyc_cpu),
   .cyc_end    (cyc_end),
   .xlat_on    (xlat_on),
   .dly_q      (dly_q),
   .fast_q     (fast_q),
   .pas        (pas),
   .berr       (berr),
   .halt       (halt),
   .lbr        (lbr),
   .la_hi      (la[ADDR_W-1:PAGE_LSB]),
   .pa_hi      (pa[ADDR_W-1:PAGE_LSB])
);

// File: tb/xlat_strobe_timer_test.sv
`timescale 1ns/1ps
module xlat_strobe_timer_test;

   localparam int ADDR_W = 32;
   localparam int PAGE_LSB = 8;
   localparam int DLY_W = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [DLY_W-1:0] cfg_dly = '0;
   logic cfg_search_fast = 1'b1;
   logic cyc_start = 0, cyc_search = 0, cyc_cpu = 0, xlat_on = 1;
   logic cmp_hit = 0, cmp_fault = 0, cyc_end = 0;
   logic [ADDR_W-1:0] la = '0;
   logic [ADDR_W-PAGE_LSB-1:0] frame = '0;
   logic [ADDR_W-1:0] pa;
   logic pas, berr, halt, lbr;

   always #10 clk = ~clk;

   xlat_strobe_timer #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .DLY_W(DLY_W)) uut (
      .clk(clk), .rst(rst), .cfg_dly(cfg_dly), .cfg_search_fast(cfg_search_fast),
      .cyc_start(cyc_start), .cyc_search(cyc_search), .cyc_cpu(cyc_cpu),
      .xlat_on(xlat_on), .cmp_hit(cmp_hit), .cmp_fault(cmp_fault), .cyc_end(cyc_end),
      .la(la), .frame(frame), .pa(pa), .pas(pas), .berr(berr), .halt(halt), .lbr(lbr));

   int tests = 0;
   int fails = 0;
   string cur_req = "R1";
   bit started = 0;
   bit done = 0;

   // behavioural reference model
   int m_cfg_d, m_cfg_f, edge_n, m_state, fire_at;
   bit m_search, m_cpu;
   logic [3:0] exp_s = 4'b0;

   always @(posedge clk) begin
      if (rst) begin
         m_cfg_d = int'(cfg_dly);
         m_cfg_f = int'(cfg_search_fast);
         m_state = 0; exp_s = 4'b0; edge_n = 0;
         started = 1;
      end else begin
         if (m_state == 0) begin
            if (cyc_start && (edge_n % 2 == 0)) begin
               int d;
               d = (m_cfg_d == 3) ? 0 : m_cfg_d;
               fire_at = edge_n + ((cyc_search && m_cfg_f == 1) ? 1 : 1 + d);
               m_search = cyc_search; m_cpu = cyc_cpu; m_state = 1;
            end
         end else if (m_state == 1) begin
            if (edge_n == fire_at) begin
               if (m_search) exp_s = 4'b1000;
               else if (m_cpu) exp_s = 4'b0000;
               else if (!xlat_on || (cmp_hit && !cmp_fault)) exp_s = 4'b1000;
               else if (cmp_hit) exp_s = 4'b0100;
               else exp_s = 4'b0011;
               m_state = (exp_s != 0) ? 2 : 0;
            end
         end else if (cyc_end) begin
            exp_s = 4'b0; m_state = 0;
         end
         edge_n = edge_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         logic [ADDR_W-1:0] exp_pa;
         exp_pa = xlat_on ? {frame, la[PAGE_LSB-1:0]} : la;
         chk({pas, berr, halt, lbr} === exp_s, cur_req, 32'({pas, berr, halt, lbr}), 32'(exp_s));
         chk(pa === exp_pa, xlat_on ? "R7" : "R6", pa, exp_pa);
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic do_reset(input int d, input bit f);
      rst = 1; cfg_dly = DLY_W'(d); cfg_search_fast = f;
      repeat (3) step();
      cur_req = "R1";
      chk({pas, berr, halt, lbr} === 4'b0, "R1", 32'({pas, berr, halt, lbr}), 0);
      rst = 0;
   endtask

   task automatic run(input string req, input bit srch, input bit cpu, input bit xl,
                      input bit h, input bit f, input int hold, input bit poke);
      cur_req = req;
      step();
      while (!(m_state == 0 && edge_n % 2 == 0)) step();
      cyc_search = srch; cyc_cpu = cpu; xlat_on = xl;
      cmp_hit = ~h; cmp_fault = ~f;
      la = la + 32'h0101_1357; frame = frame ^ 24'h5A_C3_96;
      cyc_start = 1;
      step();
      cyc_start = poke; cmp_hit = h; cmp_fault = f;
      if (poke) begin cyc_search = ~srch; cyc_cpu = ~cpu; end
      step();
      cyc_start = 0;
      while (m_state == 1) step();
      repeat (hold) begin
         if (poke) cyc_start = 1;
         step();
      end
      cyc_start = 0;
      if (m_state == 2) begin
         cyc_end = 1; step(); cyc_end = 0;
      end
      repeat (2) step();
   endtask

   initial begin
      for (int d = 0; d < 4; d++) begin
         for (int f = 0; f < 2; f++) begin
            do_reset(d, f[0]);
            run("R2", 0, 0, 1, 1, 0, 1, 0);
            run("R5", 0, 0, 1, 0, 0, 2, 0);
            run("R5", 0, 0, 1, 1, 1, 0, 0);
            run(f ? "R3" : "R4", 1, 0, 1, 0, 1, 1, 0);
            run(f ? "R3" : "R4", 1, 1, 0, 0, 0, 0, 0);
            run("R8", 0, 1, 1, 1, 0, 0, 0);
            run("R6", 0, 0, 0, 0, 1, 1, 0);
            run("R9", 0, 0, 1, 1, 0, 5, 0);
            run("R10", 0, 0, 1, 0, 0, 3, 1);
            // R10: a request on a falling-phase edge is ignored
            cur_req = "R10";
            while (!(m_state == 0 && edge_n % 2 == 1)) step();
            cyc_start = 1; step(); cyc_start = 0;
            repeat (4) step();
            chk({pas, berr, halt, lbr} === 4'b0, "R10", 32'({pas, berr, halt, lbr}), 0);
         end
      end
      // R11: configuration inputs moved after reset release have no effect
      do_reset(2, 0);
      cfg_dly = 2'd3; cfg_search_fast = 1;
      run("R11", 0, 0, 1, 1, 0, 1, 0);
      run("R11", 1, 0, 1, 1, 0, 1, 0);
      cfg_dly = 2'd1; cfg_search_fast = 0;
      do_reset(1, 1);
      run("R2", 0, 0, 1, 0, 0, 1, 0);
      run("R3", 1, 0, 1, 0, 0, 1, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule